// File: doc/BRIEF.md
# CPU Cycle Clock and Late Write Strobe Generator

This block takes a reference clock running at eight times the CPU rate. It turns it into the CPU cycle clock and a memory write strobe. A phase counter splits each CPU cycle into eighths. The CPU clock is high for the first half of the cycle and low for the second half. The active-low write strobe opens only in the eighth that starts three quarters of the way through the cycle, and it closes one eighth before the cycle ends. The CPU therefore has most of the cycle to settle a write address. The strobe is released well before the rising CPU clock edge moves the address bus.

The CPU write request is captured once per cycle, at the end of the middle phase. Later changes to the request cannot shorten or lengthen a strobe. An I/O halt flag freezes the CPU clock. While the flag is asserted, the divider is pinned to phase 0 with the clock high. When the flag drops, the sequence restarts cleanly from phase 0. All outputs are registered.

Top module: `cycle_strobe_gen`

## Requirements
- R1: While `rst` is sampled high, the next outputs are `phase` = 0, `cpu_clk` = 1 and `wr_strobe_n` = 1.
- R2: With `rst` and `io_halt` low, `phase` advances by one on every `clk_ref` edge and wraps from 7 to 0.
- R3: `cpu_clk` is 1 while `phase` is 0 to 3 and 0 while `phase` is 4 to 7.
- R4: `wr_strobe_n` is 0 during phase 6 of a CPU cycle when `mem_wr_req` was 1 at the clock edge that ended phase 4 of that cycle.
- R5: `mem_wr_req` is looked at only at the edge ending phase 4; its value during any other phase has no effect on `wr_strobe_n`.
- R6: `wr_strobe_n` stays 1 for the whole cycle when `mem_wr_req` was 0 at the edge ending phase 4.
- R7: `wr_strobe_n` is 1 in every phase other than 6, in particular in phases 7 and 0 around the rising `cpu_clk` edge.
- R8: While `io_halt` is sampled high, the following outputs are `phase` = 0, `cpu_clk` = 1 and `wr_strobe_n` = 1. After release, counting continues 1, 2, ... from phase 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock, eight times the CPU rate |
| rst | input | 1 | Synchronous reset, active high |
| io_halt | input | 1 | Freezes the CPU clock and pins the divider to phase 0 |
| mem_wr_req | input | 1 | CPU memory write request |
| cpu_clk | output | 1 | Divided CPU cycle clock |
| wr_strobe_n | output | 1 | Active-low memory write strobe |
| phase | output | 3 | Current eighth of the CPU cycle |

## Verification
The request is driven in five ways: held high, held low, alternating per CPU cycle, high only during phase 4, and high in every phase except phase 4. Together these show that a strobe depends only on the phase 4 sample and never appears outside phase 6. A halt is raised in each of the eight phases in turn and released with the request held high. This shows that the divider always restarts from phase 0 and that the first cycle after release produces a proper strobe. A reset in the middle of a strobe shows that the output is cut off at once.

// File: rtl/csg_pkg.sv
package csg_pkg;
  // Number of phases in one CPU cycle for a given counter width
  function automatic int unsigned num_phases(input int unsigned w);
    return 32'd1 << w;
  endfunction

  // First phase of the strobe window (3/4 of the cycle)
  function automatic int unsigned strobe_first(input int unsigned w);
    return (num_phases(w) * 3) / 4;
  endfunction

  // First phase after the strobe window (7/8 of the cycle)
  function automatic int unsigned strobe_after(input int unsigned w);
    return (num_phases(w) * 7) / 8;
  endfunction

  // Phase at whose end the write request is captured (mid-cycle)
  function automatic int unsigned sample_at(input int unsigned w);
    return num_phases(w) / 2;
  endfunction

  // CPU clock level for a phase: high in the first half
  function automatic logic clk_level(input int unsigned p, input int unsigned w);
    return p < (num_phases(w) / 2);
  endfunction

  // Phase lies in the write window
  function automatic logic in_window(input int unsigned p, input int unsigned w);
    return (p >= strobe_first(w)) && (p < strobe_after(w));
  endfunction
endpackage

// File: rtl/csg_phase_seq.sv
module csg_phase_seq
  import csg_pkg::*;
#(
  parameter int unsigned PHASE_W = 3
) (
  input  logic               clk_ref,
  input  logic               rst,
  input  logic               io_halt,
  output logic [PHASE_W-1:0] phase_q,
  output logic [PHASE_W-1:0] phase_nx,
  output logic               cpu_clk_q
);
  logic restart;

  assign restart = rst | io_halt;

  always_comb begin
    if (restart) phase_nx = '0;
    else         phase_nx = phase_q + 1'b1;
  end

  always_ff @(posedge clk_ref) begin
    phase_q   <= phase_nx;
    cpu_clk_q <= clk_level(int'(phase_nx), PHASE_W);
  end
endmodule

// File: rtl/csg_wr_gate.sv
module csg_wr_gate
  import csg_pkg::*;
#(
  parameter int unsigned PHASE_W = 3
) (
  input  logic               clk_ref,
  input  logic               rst,
  input  logic               io_halt,
  input  logic               mem_wr_req,
  input  logic [PHASE_W-1:0] phase_q,
  input  logic [PHASE_W-1:0] phase_nx,
  output logic               sample_evt,
  output logic               req_held,
  output logic               wr_strobe_n_q
);
  localparam int unsigned SAMPLE_PH = sample_at(PHASE_W);

  logic restart;
  logic req_nx;
  logic open_nx;

  assign restart    = rst | io_halt;
  assign sample_evt = !restart && (int'(phase_q) == SAMPLE_PH);

  always_comb begin
    if (restart)         req_nx = 1'b0;
    else if (sample_evt) req_nx = mem_wr_req;
    else                 req_nx = req_held;
  end

  assign open_nx = req_nx && in_window(int'(phase_nx), PHASE_W);

  always_ff @(posedge clk_ref) begin
    req_held      <= req_nx;
    wr_strobe_n_q <= !open_nx;
  end
endmodule

// File: rtl/cycle_strobe_gen.sv
module cycle_strobe_gen
  import csg_pkg::*;
#(
  parameter int unsigned PHASE_W = 3
) (
  input  logic               clk_ref,
  input  logic               rst,
  input  logic               io_halt,
  input  logic               mem_wr_req,
  output logic               cpu_clk,
  output logic               wr_strobe_n,
  output logic [PHASE_W-1:0] phase
);
  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] phase_nx;
  logic               cpu_clk_q;
  logic               sample_evt;
  logic               req_held;
  logic               wr_strobe_n_q;

  csg_phase_seq #(.PHASE_W(PHASE_W)) u_seq (
    .clk_ref   (clk_ref),
    .rst       (rst),
    .io_halt   (io_halt),
    .phase_q   (phase_q),
    .phase_nx  (phase_nx),
    .cpu_clk_q (cpu_clk_q)
  );

  csg_wr_gate #(.PHASE_W(PHASE_W)) u_gate (
    .clk_ref       (clk_ref),
    .rst           (rst),
    .io_halt       (io_halt),
    .mem_wr_req    (mem_wr_req),
    .phase_q       (phase_q),
    .phase_nx      (phase_nx),
    .sample_evt    (sample_evt),
    .req_held      (req_held),
    .wr_strobe_n_q (wr_strobe_n_q)
  );

  assign cpu_clk     = cpu_clk_q;
  assign wr_strobe_n = wr_strobe_n_q;
  assign phase       = phase_q;
endmodule

// File: rtl/cycle_strobe_chk.sv
module cycle_strobe_chk
  import csg_pkg::*;
#(
  parameter int unsigned PHASE_W = 3
) (
  input logic               clk_ref,
  input logic               rst,
  input logic               io_halt,
  input logic               mem_wr_req,
  input logic               cpu_clk,
  input logic               wr_strobe_n,
  input logic [PHASE_W-1:0] phase,
  input logic               sample_evt
);
  localparam int unsigned LAST_PH = num_phases(PHASE_W) - 1;
  localparam int unsigned HALF_PH = num_phases(PHASE_W) / 2;
  localparam int unsigned WIN_LO  = strobe_first(PHASE_W);
  localparam int unsigned WIN_HI  = strobe_after(PHASE_W);

  AST_RESET_STATE: assert property (@(posedge clk_ref)
    rst |=> (phase == '0 && cpu_clk && wr_strobe_n)); // R1

  AST_PHASE_STEP: assert property (@(posedge clk_ref) disable iff (rst)
    !io_halt |=> (phase == $past(phase) + 1'b1)); // R2

  AST_CLK_HALVES: assert property (@(posedge clk_ref) disable iff (rst)
    cpu_clk == (int'(phase) < HALF_PH)); // R3

  AST_STROBE_WINDOW: assert property (@(posedge clk_ref) disable iff (rst)
    !wr_strobe_n |-> (int'(phase) >= WIN_LO && int'(phase) < WIN_HI)); // R4

  AST_NO_REQ_NO_STROBE: assert property (@(posedge clk_ref) disable iff (rst)
    (sample_evt && !mem_wr_req) |=> ##1 wr_strobe_n); // R6

  AST_CLEAR_AT_WRAP: assert property (@(posedge clk_ref) disable iff (rst)
    (int'(phase) == LAST_PH || phase == '0) |-> wr_strobe_n); // R7

  AST_HALT_PINS: assert property (@(posedge clk_ref) disable iff (rst)
    io_halt |=> (phase == '0 && cpu_clk && wr_strobe_n)); // R8
endmodule

bind cycle_strobe_gen cycle_strobe_chk #(.PHASE_W(PHASE_W)) u_chk (
  .clk_ref     (clk_ref),
  .rst         (rst),
  .io_halt     (io_halt),
  .mem_wr_req  (mem_wr_req),
  .cpu_clk     (cpu_clk),
  .wr_strobe_n (wr_strobe_n),
  .phase       (phase),
  .sample_evt  (sample_evt)
);

// File: tb/cycle_strobe_gen_bench.sv
module cycle_strobe_gen_bench;
  logic       clk_ref = 1'b0;
  logic       rst = 1'b1;
  logic       io_halt = 1'b0;
  logic       mem_wr_req = 1'b0;
  logic       cpu_clk;
  logic       wr_strobe_n;
  logic [2:0] phase;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_ph  = 0;
  bit exp_req = 1'b0;
  string ph_tag = "R1";
  string st_tag = "R1";

  always #5 clk_ref = ~clk_ref;

  cycle_strobe_gen u_cycle_strobe_gen (
    .clk_ref     (clk_ref),
    .rst         (rst),
    .io_halt     (io_halt),
    .mem_wr_req  (mem_wr_req),
    .cpu_clk     (cpu_clk),
    .wr_strobe_n (wr_strobe_n),
    .phase       (phase)
  );

  task automatic check(input string tag, input int act, input int expv, input string what);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (model phase %0d)", tag, what, act, expv, exp_ph);
    end
  endtask

  // Check current outputs, drive the next inputs, then advance the model by one edge
  task automatic tick(input bit r, input bit h, input bit q);
    bit exp_low;
    @(negedge clk_ref);
    exp_low = (exp_ph == 6) && exp_req;
    check(ph_tag, int'(phase), exp_ph, "phase");
    check((ph_tag == "R2") ? "R3" : ph_tag, int'(cpu_clk), (exp_ph < 4) ? 1 : 0, "cpu_clk");
    check(exp_low ? "R4" : ((exp_ph == 7 || exp_ph == 0) ? "R7" : st_tag),
          int'(wr_strobe_n), exp_low ? 0 : 1, "wr_strobe_n");
    rst = r; io_halt = h; mem_wr_req = q;
    if (r || h) begin
      exp_ph = 0; exp_req = 1'b0;
      ph_tag = r ? "R1" : "R8";
    end else begin
      if (exp_ph == 4) exp_req = q;
      exp_ph = (exp_ph + 1) % 8;
      if (exp_ph == 3) ph_tag = "R2";
    end
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_ref);
    // R1: reset state
    tick(1, 0, 1); tick(1, 0, 1); tick(0, 0, 1);
    // R4: request held high over several cycles
    st_tag = "R4";
    for (int i = 0; i < 32; i++) tick(0, 0, 1);
    // R6: no request
    st_tag = "R6";
    for (int i = 0; i < 32; i++) tick(0, 0, 0);
    // R4/R6: request alternating per CPU cycle
    st_tag = "R6";
    for (int i = 0; i < 48; i++) tick(0, 0, ((i / 8) % 2) == 0);
    // R5: request high only during phase 4
    st_tag = "R5";
    for (int i = 0; i < 32; i++) tick(0, 0, exp_ph == 4);
    // R5: request high in every phase except phase 4
    for (int i = 0; i < 32; i++) tick(0, 0, exp_ph != 4);
    // R8: halt raised in each phase, then released with the request high
    st_tag = "R8";
    for (int p = 0; p < 8; p++) begin
      while (exp_ph != p) tick(0, 0, 1);
      for (int k = 0; k < 3 + p; k++) tick(0, 1, 1);
      for (int k = 0; k < 12; k++) tick(0, 0, 1);
    end
    // R1: reset during an open strobe
    st_tag = "R1";
    while (exp_ph != 6) tick(0, 0, 1);
    tick(1, 0, 1);
    for (int k = 0; k < 20; k++) tick(0, 0, 1);
    @(negedge clk_ref);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule